// File: doc/BRIEF.md
# PC Card Strobe Timing Sequencer

This block turns host transfer requests into timed accesses on a 16-bit PC Card / CompactFlash style bus with two card slots. Each slot has three address spaces: common memory, attribute memory and I/O. Each slot/space pair has its own timing register, so there are six registers. A register holds three codes: the address setup before the command strobe, the strobe width, and the address hold after the strobe. The bus time for each phase is the code plus two clocks.

The host programs the registers through a simple write port. It reads them back combinationally on the same port. Transfers are issued through a valid/ready request port. When a request is accepted, the block latches the request and the timing of the matching register. It then walks through setup, command and hold, and ends with a one-clock completion pulse that carries the read data. Requests with an unsupported size or space complete at once with an error flag and no bus activity.

Top module: `pccard_strobe_seq`

## Requirements
- R1: There are six timing registers, one for each slot (0, 1) and space (0 common memory, 1 attribute memory, 2 I/O). A write or request uses the register matching its slot and space. A configuration write with space code 3 changes no register.
- R2: The register fields are: hold code in bits 19:14, strobe code in bits 11:7, setup code in bits 6:0. All other bits read back as zero whatever was written.
- R3: After reset, all six registers read zero, `req_ready` is high, and the bus window, both strobes and `rsp_done` are low.
- R4: `card_bus_en` is high with `card_addr` valid for exactly setup+2 clocks before the command strobe rises.
- R5: The command strobe stays high for exactly strobe+2 clocks. `card_cmd_rd` is used for reads, `card_cmd_wr` for writes, and never both at once.
- R6: After the strobe falls, `card_bus_en` stays high with an unchanged `card_addr` for exactly hold+2 clocks.
- R7: `req_size` 0 is a byte transfer: `card_be` is 01 for an even address and 10 for an odd one. `req_size` 1 is a halfword transfer with `card_be` 11. A request with size 2 or 3, or with space 3, raises `rsp_done` and `rsp_err` in the clock after acceptance, with no bus window and no strobe.
- R8: `rsp_done` is a one-clock pulse in the clock after the hold phase. For a read, `rsp_rdata` then shows `card_rdata` as sampled in the last strobe clock.
- R9: `req_ready` is low from acceptance through the completion clock. A request held valid in that time is accepted in the first clock after completion and is not lost.
- R10: A register write during an access does not change that access's timing. It applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_slot | input | 1 | Register slot select |
| cfg_space | input | 2 | Register space select (0 common, 1 attribute, 2 I/O) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_slot | input | 1 | Request slot |
| req_space | input | 2 | Request space |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, other codes rejected |
| req_wdata | input | DW | Write data |
| card_rdata | input | DW | Data returned by the card |
| card_bus_en | output | 1 | Access window: address valid |
| card_slot | output | 1 | Slot of the current access |
| card_space | output | 2 | Space of the current access |
| card_addr | output | AW | Card address |
| card_be | output | 2 | Byte lane enables |
| card_cmd_rd | output | 1 | Read command strobe |
| card_cmd_wr | output | 1 | Write command strobe |
| card_wdata | output | DW | Write data to the card |
| card_wdata_oe | output | 1 | Write data drive enable |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Completion carries an error |
| rsp_rdata | output | DW | Read data |

## Verification
Take the clock after the accepting edge as clock 0, with register codes S, A and H. Setup occupies clocks 0 to S+1. The strobe occupies S+2 to S+A+3. Hold occupies S+A+4 to S+A+H+5. `rsp_done` is high in clock S+A+H+6, and `req_ready` returns one clock later; a rejected request shows `rsp_done` in clock 0. The bench samples once per clock on the falling edge, counts the clocks of each phase, and compares each count with the code plus two. It changes `card_rdata` every clock, so only the value from the last strobe clock matches the returned data. Read-back of a register is combinational and is sampled shortly after the select changes.

// File: rtl/pccard_strobe_seq.sv
module pccard_strobe_seq #(
  parameter int AW = 26,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_slot,
  input  logic [1:0]    cfg_space,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_slot,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] card_rdata,
  output logic          card_bus_en,
  output logic          card_slot,
  output logic [1:0]    card_space,
  output logic [AW-1:0] card_addr,
  output logic [1:0]    card_be,
  output logic          card_cmd_rd,
  output logic          card_cmd_wr,
  output logic [DW-1:0] card_wdata,
  output logic          card_wdata_oe,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  localparam int NREG = 6;
  localparam int CW = 8;
  localparam logic [31:0] KEEP = 32'h000F_CFFF;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CMD, S_HOLD, S_DONE} st_t;

  function automatic logic [2:0] reg_idx(input logic slot, input logic [1:0] sp);
    return slot ? ({1'b0, sp} + 3'd3) : {1'b0, sp};
  endfunction

  st_t            st;
  logic [31:0]    regs [NREG];
  logic [CW-1:0]  cnt;
  logic [4:0]     asst_q;
  logic [5:0]     hold_q;
  logic           wr_q, err_q;
  logic [DW-1:0]  rdata_q;

  wire        cfg_ok  = cfg_space != 2'd3;
  wire [2:0]  cidx    = reg_idx(cfg_slot, cfg_space);
  wire [2:0]  ridx    = reg_idx(req_slot, req_space);
  wire        req_bad = (req_space == 2'd3) || req_size[1];
  wire [31:0] sel_t   = req_bad ? 32'd0 : regs[ridx];
  wire        cnt_end = cnt == '0;

  assign cfg_rdata     = cfg_ok ? regs[cidx] : 32'd0;
  assign req_ready     = st == S_IDLE;
  assign card_bus_en   = st == S_SETUP || st == S_CMD || st == S_HOLD;
  assign card_cmd_rd   = st == S_CMD && !wr_q;
  assign card_cmd_wr   = st == S_CMD && wr_q;
  assign card_wdata_oe = card_bus_en && wr_q;
  assign rsp_done      = st == S_DONE;
  assign rsp_err       = rsp_done && err_q;
  assign rsp_rdata     = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      st         <= S_IDLE;
      cnt        <= '0;
      asst_q     <= '0;
      hold_q     <= '0;
      wr_q       <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
      card_slot  <= 1'b0;
      card_space <= '0;
      card_addr  <= '0;
      card_be    <= '0;
      card_wdata <= '0;
    end else begin
      if (cfg_we && cfg_ok) regs[cidx] <= cfg_wdata & KEEP;
      case (st)
        S_IDLE: if (req_valid) begin
          card_slot  <= req_slot;
          card_space <= req_space;
          card_addr  <= req_addr;
          card_wdata <= req_wdata;
          card_be    <= req_size[0] ? 2'b11 : (req_addr[0] ? 2'b10 : 2'b01);
          wr_q       <= req_write;
          asst_q     <= sel_t[11:7];
          hold_q     <= sel_t[19:14];
          err_q      <= req_bad;
          cnt        <= {1'b0, sel_t[6:0]} + 8'd1;
          st         <= req_bad ? S_DONE : S_SETUP;
        end
        S_SETUP: if (cnt_end) begin
          cnt <= {3'b0, asst_q} + 8'd1;
          st  <= S_CMD;
        end else cnt <= cnt - 8'd1;
        S_CMD: if (cnt_end) begin
          rdata_q <= card_rdata;
          cnt     <= {2'b0, hold_q} + 8'd1;
          st      <= S_HOLD;
        end else cnt <= cnt - 8'd1;
        S_HOLD: if (cnt_end) st <= S_DONE;
                else cnt <= cnt - 8'd1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pccard_strobe_seq_chk.sv
module pccard_strobe_seq_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          card_bus_en,
  input logic          card_cmd_rd,
  input logic          card_cmd_wr,
  input logic [AW-1:0] card_addr,
  input logic          rsp_done,
  input logic          rsp_err
);
  wire cmd = card_cmd_rd || card_cmd_wr;

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_cmd_rd && card_cmd_wr));
  p_cmd_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |-> card_bus_en);
  p_setup_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd) |-> $past(card_bus_en) && $past(card_bus_en, 2));
  p_cmd_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd) |-> $past(cmd, 2));
  p_hold_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd) |-> card_bus_en ##1 card_bus_en);
  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    card_bus_en && $past(card_bus_en) |-> $stable(card_addr));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (card_bus_en || rsp_done) |-> !req_ready);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done && !card_bus_en && !cmd);
endmodule

bind pccard_strobe_seq pccard_strobe_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .card_bus_en(card_bus_en),
  .card_cmd_rd(card_cmd_rd), .card_cmd_wr(card_cmd_wr), .card_addr(card_addr),
  .rsp_done(rsp_done), .rsp_err(rsp_err)
);

// File: tb/pccard_strobe_seq_bench.sv
module pccard_strobe_seq_bench;
  localparam int AW = 26;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_slot = 1'b0;
  logic [1:0] cfg_space = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_slot = 1'b0, req_write = 1'b0;
  logic [1:0] req_space = '0, req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, card_rdata = '0;
  logic card_bus_en, card_slot, card_cmd_rd, card_cmd_wr, card_wdata_oe;
  logic [1:0] card_space, card_be;
  logic [AW-1:0] card_addr;
  logic [DW-1:0] card_wdata, rsp_rdata;
  logic rsp_done, rsp_err;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  pccard_strobe_seq #(.AW(AW), .DW(DW)) u_pccard_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_space(cfg_space), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
    .req_space(req_space), .req_addr(req_addr), .req_write(req_write),
    .req_size(req_size), .req_wdata(req_wdata), .card_rdata(card_rdata),
    .card_bus_en(card_bus_en), .card_slot(card_slot), .card_space(card_space),
    .card_addr(card_addr), .card_be(card_be), .card_cmd_rd(card_cmd_rd),
    .card_cmd_wr(card_cmd_wr), .card_wdata(card_wdata),
    .card_wdata_oe(card_wdata_oe), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int s, input int a, input int h);
    return (32'(h) << 14) | (32'(a) << 7) | 32'(s);
  endfunction

  task automatic cfg_write(input logic sl, input logic [1:0] sp, input logic [31:0] v);
    @(negedge clk);
    cfg_slot = sl; cfg_space = sp; cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic sl, input logic [1:0] sp, output logic [31:0] v);
    cfg_slot = sl; cfg_space = sp;
    #1 v = cfg_rdata;
  endtask

  task automatic issue(input logic sl, input logic [1:0] sp, input logic [AW-1:0] a,
                       input logic w, input logic [1:0] sz);
    @(negedge clk);
    req_slot = sl; req_space = sp; req_addr = a; req_write = w; req_size = sz;
    req_wdata = 16'h5A00 ^ a[15:0]; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic monitor(input int s_c, input int a_c, input int h_c, input logic [AW-1:0] ea,
                         input logic w, input logic [1:0] ebe, input bit drop, input string tag);
    int s = 0, c = 0, h = 0;
    bit seen = 0, got = 0, bad_addr = 0, bad_kind = 0, bad_rdy = 0;
    logic [15:0] exp_rd = '0;
    for (int k = 0; k < 600 && !got; k++) begin
      @(negedge clk);
      if (k == 0 && drop) req_valid = 1'b0;
      if (rsp_done) got = 1;
      else begin
        if (req_ready) bad_rdy = 1;
        if (card_bus_en && card_addr != ea) bad_addr = 1;
        if (card_bus_en && card_wdata_oe != w) bad_kind = 1;
        if (card_cmd_rd || card_cmd_wr) begin
          c++; seen = 1;
          if (card_cmd_wr != w || card_cmd_rd == w) bad_kind = 1;
        end else if (card_bus_en) begin
          if (seen) h++; else s++;
        end
        card_rdata = 16'hC000 + 16'(k);
        if (card_cmd_rd) exp_rd = card_rdata;
      end
    end
    chk(got, {tag, " R8 done seen"}, 32'(got), 1);
    chk(s == s_c + 2, {tag, " R4 setup clocks"}, 32'(s), 32'(s_c + 2));
    chk(c == a_c + 2, {tag, " R5 strobe clocks"}, 32'(c), 32'(a_c + 2));
    chk(h == h_c + 2, {tag, " R6 hold clocks"}, 32'(h), 32'(h_c + 2));
    chk(!bad_addr, {tag, " R6 address stable"}, 32'(bad_addr), 0);
    chk(!bad_kind, {tag, " R5 strobe kind"}, 32'(bad_kind), 0);
    chk(!bad_rdy, {tag, " R9 ready low while busy"}, 32'(bad_rdy), 0);
    chk(card_be == ebe, {tag, " R7 byte lanes"}, 32'(card_be), 32'(ebe));
    chk(!rsp_err, {tag, " R7 no error"}, 32'(rsp_err), 0);
    if (!w) chk(rsp_rdata == exp_rd, {tag, " R8 read data"}, 32'(rsp_rdata), 32'(exp_rd));
    @(negedge clk);
    chk(!rsp_done, {tag, " R8 done one clock"}, 32'(rsp_done), 0);
    chk(req_ready, {tag, " R9 ready after done"}, 32'(req_ready), 1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      cfg_read(i >= 3, 2'(i % 3), v);
      chk(v == 0, "R3 register reset", v, 0);
    end
    chk(req_ready && !card_bus_en && !card_cmd_rd && !card_cmd_wr && !rsp_done,
        "R3 idle outputs", {27'd0, req_ready, card_bus_en, card_cmd_rd, card_cmd_wr, rsp_done}, 32'h10);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    cfg_write(1'b0, 2'd0, 32'hFFFF_FFFF);
    cfg_read(1'b0, 2'd0, v);
    chk(v == 32'h000F_CFFF, "R2 reserved bits read zero", v, 32'h000F_CFFF);
    for (int i = 0; i < 6; i++) cfg_write(i >= 3, 2'(i % 3), mk(i + 10, i + 1, i + 20));
    cfg_write(1'b1, 2'd3, 32'h000F_CFFF);
    cfg_write(1'b0, 2'd3, 32'h000F_CFFF);
    for (int i = 0; i < 6; i++) begin
      cfg_read(i >= 3, 2'(i % 3), v);
      chk(v == mk(i + 10, i + 1, i + 20), "R1 per slot/space register", v, mk(i + 10, i + 1, i + 20));
    end
  endtask

  task automatic t_min_read;
    cfg_write(1'b0, 2'd0, 32'd0);
    issue(1'b0, 2'd0, 26'h100, 1'b0, 2'd0);
    monitor(0, 0, 0, 26'h100, 1'b0, 2'b01, 1, "min read");
  endtask

  task automatic t_long_write;
    cfg_write(1'b1, 2'd2, mk(3, 4, 5));
    issue(1'b1, 2'd2, 26'h2344, 1'b1, 2'd1);
    chk(card_wdata == (16'h5A00 ^ 16'h2344), "R5 write data", 32'(card_wdata), 32'(16'h5A00 ^ 16'h2344));
    monitor(3, 4, 5, 26'h2344, 1'b1, 2'b11, 1, "io write");
    cfg_write(1'b0, 2'd0, mk(127, 31, 63));
    issue(1'b0, 2'd0, 26'h3FF_FFFE, 1'b0, 2'd1);
    monitor(127, 31, 63, 26'h3FF_FFFE, 1'b0, 2'b11, 1, "max codes");
  endtask

  task automatic t_select;
    cfg_write(1'b0, 2'd1, mk(1, 0, 2));
    cfg_write(1'b1, 2'd1, mk(5, 2, 0));
    issue(1'b0, 2'd1, 26'h0777, 1'b0, 2'd0);
    chk(card_slot == 1'b0 && card_space == 2'd1, "R1 slot/space out", {card_slot, card_space}, 3'b001);
    monitor(1, 0, 2, 26'h0777, 1'b0, 2'b10, 1, "R1 slot0 attr");
    issue(1'b1, 2'd1, 26'h0778, 1'b1, 2'd0);
    monitor(5, 2, 0, 26'h0778, 1'b1, 2'b01, 1, "R1 slot1 attr");
  endtask

  task automatic t_busy;
    cfg_write(1'b0, 2'd2, mk(2, 1, 0));
    issue(1'b0, 2'd2, 26'h0040, 1'b0, 2'd1);
    req_addr = 26'h0042; req_write = 1'b1;
    monitor(2, 1, 0, 26'h0040, 1'b0, 2'b11, 0, "R9 first");
    monitor(2, 1, 0, 26'h0042, 1'b1, 2'b11, 1, "R9 queued");
  endtask

  task automatic t_midwrite;
    cfg_write(1'b0, 2'd0, mk(1, 1, 1));
    issue(1'b0, 2'd0, 26'h0900, 1'b0, 2'd1);
    fork
      monitor(1, 1, 1, 26'h0900, 1'b0, 2'b11, 1, "R10 old timing");
      begin
        repeat (2) @(negedge clk);
        cfg_write(1'b0, 2'd0, mk(6, 6, 6));
      end
    join
    issue(1'b0, 2'd0, 26'h0902, 1'b0, 2'd1);
    monitor(6, 6, 6, 26'h0902, 1'b0, 2'b11, 1, "R10 new timing");
  endtask

  task automatic t_bad(input logic [1:0] sp, input logic [1:0] sz);
    issue(1'b0, sp, 26'h0010, 1'b0, sz);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_done && rsp_err && !card_bus_en && !card_cmd_rd && !card_cmd_wr,
        "R7 rejected request", {28'd0, rsp_done, rsp_err, card_bus_en, card_cmd_rd | card_cmd_wr}, 32'hC);
    @(negedge clk);
    chk(!rsp_done && req_ready, "R7 rejected completes in one clock", {30'd0, rsp_done, req_ready}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_min_read();
    t_long_write();
    t_select();
    t_busy();
    t_midwrite();
    t_bad(2'd0, 2'd2);
    t_bad(2'd3, 2'd1);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule